// File: doc/BRIEF.md
# Page-Aligned Record Packer

The block sits between a data acquisition stream and the write master of a paged serial EEPROM. Fixed-length records arrive one byte at a time. Each record goes into its own slot. A slot is a power-of-two number of bytes, no larger than a 64-byte page. Slots lie back to back in one linear address space. Because every slot starts on a multiple of its own size, no write burst can run past the end of a page. A page wrap inside the memory device therefore cannot overwrite earlier data.

For each slot the block first presents a burst header: the start address and the burst length, which is always one slot. It then delivers exactly one slot of bytes on its output stream. A record that ends early is filled with zero bytes up to the slot length. A record that runs past the slot is cut at the slot boundary. Its remaining bytes are discarded and a sticky error flag is raised. The address counter wraps from the top of the address space back to zero and pulses a flag when it does so.

Top module: `rec_packer`

## Requirements
- R1: After reset the header channel is valid with address 0, while `out_valid_o`, `in_ready_o`, `wrap_o` and `ovf_o` are all 0.
- R2: Each slot's header (`hdr_valid_o` high, `hdr_len_o` equal to SLOT_BYTES) is accepted before any byte of that slot leaves. Exactly SLOT_BYTES output bytes follow each accepted header. No input or output byte moves while a header is pending.
- R3: Record bytes leave on `out_data_o` unchanged and in arrival order.
- R4: A record that ends (`in_last_i` high) before its slot is full is followed by zero bytes up to the slot length. `in_ready_o` stays low while these pad bytes are sent.
- R5: A record exactly SLOT_BYTES long gets no pad bytes, and the next slot's header follows it directly.
- R6: Consecutive header addresses rise by SLOT_BYTES modulo 2^ADDR_W, starting from 0 after reset. Every address is a multiple of SLOT_BYTES.
- R7: When a slot ends at the top of the 2^ADDR_W byte space, the next address is 0 and `wrap_o` is high for exactly one cycle.
- R8: If a record still has bytes after its SLOT_BYTES-th byte, only the first SLOT_BYTES bytes are sent. The rest are accepted and discarded, up to and including the one marked `in_last_i`. `ovf_o` then goes high and stays high until reset.
- R9: With `out_ready_i` and `hdr_ready_i` throttled, no byte is lost or duplicated, and a pending header holds its address.
- R10: The configuration must satisfy all of the following, or elaboration fails: SLOT_BYTES is a power of two from 2 to 64, and REC_LEN is from 1 to SLOT_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | DATA_W | Record byte |
| in_valid_i | input | 1 | Record byte valid |
| in_last_i | input | 1 | Marks the final byte of a record |
| in_ready_o | output | 1 | Record byte accepted when high together with valid |
| hdr_valid_o | output | 1 | Burst header valid |
| hdr_ready_i | input | 1 | Burst header taken by the write master |
| hdr_addr_o | output | ADDR_W | Burst start address |
| hdr_len_o | output | LEN_W | Burst length in bytes |
| out_data_o | output | DATA_W | Burst byte |
| out_valid_o | output | 1 | Burst byte valid |
| out_ready_i | input | 1 | Burst byte taken by the write master |
| wrap_o | output | 1 | One-cycle pulse when the address returns to 0 |
| ovf_o | output | 1 | Sticky flag: a record was cut at its slot boundary |

## Verification
The address wrap is the hardest state to reach from the ports. It only happens after 2^ADDR_W / SLOT_BYTES slots, which is 1024 with the default settings. The bench gets there by streaming one-byte records, so each slot is mostly pad bytes produced by the block itself. It checks that `wrap_o` stays silent until the final slot and pulses exactly once at it. Overflow is the other awkward case. A record longer than its slot is sent while output backpressure is off, and the bench checks that the discarded tail never reaches the output and that the next record still lands in the following slot.

// File: rtl/rp_pkg.sv
`timescale 1ns/1ps
package rp_pkg;
  localparam int unsigned PAGE_BYTES = 64;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_PAD  = 2'd2,
    ST_DROP = 2'd3
  } rp_state_e;
endpackage

// File: rtl/rp_addr_ctr.sv
`timescale 1ns/1ps
module rp_addr_ctr #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned SLOT_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wrap_o
);
  localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(SLOT_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W:0]   sum;
  logic              wrap_q;

  assign sum = {1'b0, addr_q} + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= adv_i & sum[ADDR_W];
      if (adv_i) addr_q <= sum[ADDR_W-1:0];
    end
  end

  assign addr_o = addr_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/rp_ctrl.sv
`timescale 1ns/1ps
module rp_ctrl
  import rp_pkg::*;
#(
  parameter int unsigned SLOT_BYTES = 32,
  localparam int unsigned CNT_W     = $clog2(SLOT_BYTES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic in_last_i,
  input  logic hdr_ready_i,
  input  logic out_ready_i,
  output logic in_ready_o,
  output logic hdr_valid_o,
  output logic out_valid_o,
  output logic pad_o,
  output logic adv_o,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SLOT_BYTES - 1);

  rp_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ovf_q, ovf_d;
  logic              cnt_last;

  assign cnt_last = (cnt_q == CNT_TOP);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    ovf_d       = ovf_q;
    adv_o       = 1'b0;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    hdr_valid_o = 1'b0;
    pad_o       = 1'b0;
    unique case (state_q)
      ST_HDR: begin
        hdr_valid_o = 1'b1;
        if (hdr_ready_i) begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end
      end
      ST_DATA: begin
        // pass-through: no storage between input and output
        in_ready_o  = out_ready_i;
        out_valid_o = in_valid_i;
        if (in_valid_i && out_ready_i) begin
          if (cnt_last) begin
            adv_o = 1'b1;
            if (in_last_i) begin
              state_d = ST_HDR;
            end else begin
              state_d = ST_DROP;
              ovf_d   = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
            if (in_last_i) state_d = ST_PAD;
          end
        end
      end
      ST_PAD: begin
        out_valid_o = 1'b1;
        pad_o       = 1'b1;
        if (out_ready_i) begin
          if (cnt_last) begin
            adv_o   = 1'b1;
            state_d = ST_HDR;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_DROP: begin
        in_ready_o = 1'b1;
        if (in_valid_i && in_last_i) state_d = ST_HDR;
      end
      default: state_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
    end
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/rp_byte_mux.sv
`timescale 1ns/1ps
module rp_byte_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              pad_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign data_o[b] = data_i[b] & ~pad_i;
  end
endmodule

// File: rtl/rec_packer.sv
`timescale 1ns/1ps
module rec_packer
  import rp_pkg::*;
#(
  parameter int unsigned REC_LEN    = 30,
  parameter int unsigned SLOT_BYTES = 32,
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned LEN_W     = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              hdr_valid_o,
  input  logic              hdr_ready_i,
  output logic [ADDR_W-1:0] hdr_addr_o,
  output logic [LEN_W-1:0]  hdr_len_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              wrap_o,
  output logic              ovf_o
);
  localparam bit CFG_OK = (SLOT_BYTES >= 2) && (SLOT_BYTES <= PAGE_BYTES)
                       && ((SLOT_BYTES & (SLOT_BYTES - 1)) == 0)
                       && (REC_LEN >= 1) && (REC_LEN <= SLOT_BYTES)
                       && (ADDR_W > $clog2(SLOT_BYTES));

  if (!CFG_OK) begin : g_cfg_bad
    $error("rec_packer: slot must be a power of two in 2..64 and hold the record");
  end

  logic pad, adv;

  rp_ctrl #(.SLOT_BYTES(SLOT_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_last_i   (in_last_i),
    .hdr_ready_i (hdr_ready_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .hdr_valid_o (hdr_valid_o),
    .out_valid_o (out_valid_o),
    .pad_o       (pad),
    .adv_o       (adv),
    .ovf_o       (ovf_o)
  );

  rp_addr_ctr #(.ADDR_W(ADDR_W), .SLOT_BYTES(SLOT_BYTES)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .addr_o (hdr_addr_o),
    .wrap_o (wrap_o)
  );

  rp_byte_mux #(.DATA_W(DATA_W)) u_mux (
    .data_i (in_data_i),
    .pad_i  (pad),
    .data_o (out_data_o)
  );

  assign hdr_len_o = LEN_W'(SLOT_BYTES);
endmodule

// File: rtl/rec_packer_chk.sv
`timescale 1ns/1ps
module rec_packer_chk #(
  parameter int unsigned REC_LEN    = 30,
  parameter int unsigned SLOT_BYTES = 32,
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hdr_valid_o,
  input logic              hdr_ready_i,
  input logic [ADDR_W-1:0] hdr_addr_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              in_ready_o,
  input logic              wrap_o,
  input logic              ovf_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SLOT_BYTES);

  logic [ADDR_W-1:0] prev_q;
  logic [7:0]        bytes_q;
  logic              seen_q;
  logic              hdr_fire, out_fire;

  assign hdr_fire = hdr_valid_o & hdr_ready_i;
  assign out_fire = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      bytes_q <= '0;
      seen_q  <= 1'b0;
    end else if (hdr_fire) begin
      prev_q  <= hdr_addr_o;
      bytes_q <= '0;
      seen_q  <= 1'b1;
    end else if (out_fire) begin
      bytes_q <= bytes_q + 8'd1;
    end
  end

  initial begin
    a_r10_slot_cfg: assert ((SLOT_BYTES & (SLOT_BYTES - 1)) == 0 && SLOT_BYTES >= 2
                            && SLOT_BYTES <= 64 && REC_LEN >= 1 && REC_LEN <= SLOT_BYTES)
      else $error("a_r10_slot_cfg");
  end

  a_r2_hdr_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (!out_valid_o && !in_ready_o));

  a_r2_slot_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && seen_q) |-> (bytes_q == 8'(SLOT_BYTES)));

  a_r4_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !in_ready_o) |-> (out_data_o == '0));

  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && seen_q) |-> (hdr_addr_o == ADDR_W'(prev_q + STEP)));

  a_r6_addr_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> ((hdr_addr_o & (STEP - ADDR_W'(1))) == '0));

  a_r7_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (hdr_addr_o == '0));

  a_r7_wrap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  a_r9_hdr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && !hdr_ready_i) |=> (hdr_valid_o && $stable(hdr_addr_o)));
endmodule

bind rec_packer rec_packer_chk #(
  .REC_LEN(REC_LEN), .SLOT_BYTES(SLOT_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hdr_valid_o (hdr_valid_o),
  .hdr_ready_i (hdr_ready_i),
  .hdr_addr_o  (hdr_addr_o),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .in_ready_o  (in_ready_o),
  .wrap_o      (wrap_o),
  .ovf_o       (ovf_o)
);

// File: tb/tb_rec_packer.sv
`timescale 1ns/1ps
module tb_rec_packer;
  localparam int SLOT  = 32;
  localparam int AW    = 15;
  localparam int NSLOT = (1 << AW) / SLOT;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_valid = 1'b0, in_last = 1'b0;
  logic          in_ready_o;
  logic          hdr_valid_o;
  logic          hdr_ready = 1'b0;
  logic [AW-1:0] hdr_addr_o;
  logic [6:0]    hdr_len_o;
  logic [7:0]    out_data_o;
  logic          out_valid_o;
  logic          out_ready = 1'b1;
  logic          wrap_o, ovf_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0, bp_en = 0, hdr_en = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [AW-1:0] exp_addr = '0;
  logic [AW-1:0] hdr_log[$], exp_hdr[$];
  logic [7:0]    byte_log[$], exp_byte[$];
  int wrap_cnt = 0, hp = 0, bp = 0;

  always #4 clk = ~clk;

  rec_packer #(.REC_LEN(30), .SLOT_BYTES(SLOT), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_last_i(in_last), .in_ready_o(in_ready_o),
    .hdr_valid_o(hdr_valid_o), .hdr_ready_i(hdr_ready), .hdr_addr_o(hdr_addr_o), .hdr_len_o(hdr_len_o),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready),
    .wrap_o(wrap_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // throttle driver
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    hdr_ready = bp_en ? lfsr[3] : hdr_en;
  end

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_ni) begin
      if (hdr_valid_o && hdr_ready) begin
        hdr_log.push_back(hdr_addr_o);
        chk(hdr_len_o == 7'(SLOT), "R2", "burst length", int'(hdr_len_o), SLOT);
      end
      if (out_valid_o && out_ready) byte_log.push_back(out_data_o);
      if (wrap_o) wrap_cnt++;
    end
  end

  task automatic push_byte(input logic [7:0] d, input bit l);
    in_data = d; in_valid = 1'b1; in_last = l;
    forever begin
      @(negedge clk);
      if (in_ready_o) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_rec(input int n, input logic [7:0] seed);
    exp_hdr.push_back(exp_addr);
    exp_addr = exp_addr + AW'(SLOT);
    for (int i = 0; i < SLOT; i++) exp_byte.push_back(i < n ? seed + 8'(i) : 8'h00);
    for (int i = 0; i < n; i++) push_byte(seed + 8'(i), i == n - 1);
  endtask

  task automatic drain();
    repeat (4 * SLOT) @(posedge clk);
    #1;
  endtask

  task automatic compare(input string req);
    chk(hdr_log.size() >= exp_hdr.size(), req, "header count", hdr_log.size(), exp_hdr.size());
    for (; hp < exp_hdr.size() && hp < hdr_log.size(); hp++)
      chk(hdr_log[hp] == exp_hdr[hp], req, "header address", int'(hdr_log[hp]), int'(exp_hdr[hp]));
    chk(byte_log.size() == exp_byte.size(), req, "byte count", byte_log.size(), exp_byte.size());
    for (; bp < exp_byte.size() && bp < byte_log.size(); bp++)
      chk(byte_log[bp] == exp_byte[bp], req, "byte value", int'(byte_log[bp]), int'(exp_byte[bp]));
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    rst_ni = 1'b0; hdr_en = 0; bp_en = 0;
    @(negedge clk);
    // R1: reset state
    chk(hdr_valid_o == 1'b1, "R1", "hdr_valid", hdr_valid_o, 1);
    chk(hdr_addr_o == '0, "R1", "hdr_addr", int'(hdr_addr_o), 0);
    chk(out_valid_o == 1'b0, "R1", "out_valid", out_valid_o, 0);
    chk(in_ready_o == 1'b0, "R1", "in_ready", in_ready_o, 0);
    chk(wrap_o == 1'b0, "R1", "wrap", wrap_o, 0);
    chk(ovf_o == 1'b0, "R1 R8", "ovf cleared", ovf_o, 0);
    hdr_log.delete(); exp_hdr.delete(); byte_log.delete(); exp_byte.delete();
    hp = 0; bp = 0; wrap_cnt = 0; exp_addr = '0;
    @(posedge clk); #1;
    rst_ni = 1'b1; hdr_en = 1;
    @(posedge clk); #1;
  endtask

  task automatic t_exact();
    // R5 and R3: full-length records, no pad; R6 addresses step
    send_rec(SLOT, 8'h10);
    send_rec(SLOT, 8'h80);
    drain();
    compare("R5 R3 R6");
    chk(ovf_o == 1'b0, "R5", "no overflow on exact fit", ovf_o, 0);
  endtask

  task automatic t_short();
    // R4: short records padded with zeros
    send_rec(30, 8'h41);
    send_rec(1, 8'hC3);
    send_rec(17, 8'hF0);
    drain();
    compare("R4");
  endtask

  task automatic t_backpr();
    // R9: throttled header and output
    bp_en = 1;
    send_rec(30, 8'h21);
    send_rec(SLOT, 8'h61);
    send_rec(5, 8'hE1);
    drain(); drain();
    bp_en = 0;
    drain();
    compare("R9");
  endtask

  task automatic t_ovf();
    // R8: 37-byte record cut to 32, tail dropped, next record in next slot
    send_rec(SLOT + 5, 8'h01);
    send_rec(5, 8'h90);
    drain();
    compare("R8");
    chk(ovf_o == 1'b1, "R8", "ovf set", ovf_o, 1);
    send_rec(3, 8'h33);
    drain();
    chk(ovf_o == 1'b1, "R8", "ovf sticky", ovf_o, 1);
    compare("R8");
  endtask

  task automatic t_wrap();
    // R7: run to the top of the address space with one-byte records
    while (exp_hdr.size() < NSLOT - 1) send_rec(1, 8'(exp_hdr.size()));
    drain();
    chk(wrap_cnt == 0, "R7", "no wrap before top", wrap_cnt, 0);
    compare("R7");
    send_rec(1, 8'h5A);
    drain();
    chk(wrap_cnt == 1, "R7", "single one-cycle wrap pulse", wrap_cnt, 1);
    chk(hdr_log.size() > NSLOT, "R7", "next header seen", hdr_log.size(), NSLOT + 1);
    if (hdr_log.size() > NSLOT)
      chk(hdr_log[NSLOT] == '0, "R7", "address after wrap", int'(hdr_log[NSLOT]), 0);
    compare("R7 R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all R): actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_exact();
    t_short();
    t_backpr();
    t_ovf();
    t_reset();
    t_wrap();
    t_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule